// File: doc/BRIEF.md
# Five-Level Flying-Capacitor Dual-Buck Switch-State Selector

This block is the synchronous gate logic for a pair of five-level flying-capacitor buck legs that share one output in a dual-buck arrangement. Each clock it reads the polarity of the current reference, a two-bit code for the region of the voltage reference, one PWM bit from an external carrier comparator, and a digitized outer flying-capacitor voltage for each leg. The setpoint and hysteresis margin for those voltages are common to both legs. From these inputs it drives three gate signals per leg.

Only the leg that owns the present half cycle switches, and the idle leg is held off. Within a region, the PWM bit picks one of the two output levels that bound that region. Where a level can be made with more than one switch combination, the block uses a hysteresis decision on the capacitor voltage of that leg. It picks the combination that charges or discharges the outer flying capacitor as that decision demands. All gate outputs are registered.

Top module: `fcdb_switch_selector`

## Requirements
- R1: When `cur_neg` is 0, `gate_b` is 000 and `gate_a` carries the selected state. When `cur_neg` is 1, `gate_a` is 000 and `gate_b` carries it. The two are never both nonzero.
- R2: Region codes 0 to 3 name the four output bands, ordered from the most negative to the most positive. With region code r, `pwm`=0 selects level r and `pwm`=1 selects level r+1. Levels 0 to 4 stand for -Ud/2, -Ud/4, 0, +Ud/4 and +Ud/2.
- R3: Each gate bus is ordered {outer, middle, inner} switch, with bit 2 being the outer switch. For leg A, level 0 gives 000 and level 4 gives 111.
- R4: For leg A under a discharge demand, level 1 gives 010, level 2 gives 011 and level 3 gives 110. Under a charge demand, level 1 gives 001, level 2 gives 100 and level 3 gives 101. A charge demand never yields 010, 011 or 110, and a discharge demand never yields 100 or 101.
- R5: Each leg's demand becomes discharge when its sample is above `setpoint`+`margin`. It becomes charge when sample+`margin` is below `setpoint`. Otherwise it keeps its previous value, so a sample exactly on either threshold holds the demand. A sample takes effect in the gate value registered at the same edge.
- R6: Leg B is the mirror of leg A. For level L, `gate_b` takes the leg-A pattern for level 4-L, chosen by leg B's own demand, which comes from `cap2_sample`.
- R7: After reset, both demands are charge.
- R8: Gate outputs change only at a rising clock edge. They hold their value while inputs change between edges.
- R9: While `rst` is high at an edge, all six gate outputs become 0.
- R10: A leg's demand keeps tracking its sample while that leg is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_neg | input | 1 | 1 when the current reference is below zero |
| region | input | 2 | Voltage reference band code |
| pwm | input | 1 | Carrier comparator result |
| cap1_sample | input | 12 | Leg A outer flying-capacitor voltage |
| cap2_sample | input | 12 | Leg B outer flying-capacitor voltage |
| setpoint | input | 12 | Balance setpoint for both capacitors |
| margin | input | 12 | Hysteresis half-width |
| gate_a | output | 3 | Leg A gates {outer, middle, inner} |
| gate_b | output | 3 | Leg B gates {outer, middle, inner} |

## Verification
The hardest case to reach is a redundant-level choice that depends on the stored demand rather than on the present sample. It can only be seen after a sample has left the band and then come back inside it. The stimulus first pushes a sample out of the band, then returns it to the middle or exactly onto a threshold, and checks the gate pattern at each step. The idle-leg case needs the same care. Leg B's sample is driven past a threshold while leg A owns the half cycle. The half cycle is then handed over with the sample back in the band, so the demand that was recorded while idle shows up on `gate_b`.

// File: rtl/fcdb_pkg.sv
package fcdb_pkg;

    localparam int GATE_W  = 3;
    localparam int LEVEL_W = 3;
    localparam int TOP_LVL = 4;

    typedef logic [GATE_W-1:0]  gate_t;
    typedef logic [LEVEL_W-1:0] level_t;

    typedef enum logic {
        BAL_CHARGE    = 1'b0,
        BAL_DISCHARGE = 1'b1
    } bal_t;

    // Switch pattern {outer, middle, inner} for a level seen from the leg's own pole.
    function automatic gate_t pick_state(level_t lvl, bal_t mode);
        gate_t st;
        case (lvl)
            3'd0:    st = 3'b000;
            3'd1:    st = (mode == BAL_DISCHARGE) ? 3'b010 : 3'b001;
            3'd2:    st = (mode == BAL_DISCHARGE) ? 3'b011 : 3'b100;
            3'd3:    st = (mode == BAL_DISCHARGE) ? 3'b110 : 3'b101;
            3'd4:    st = 3'b111;
            default: st = 3'b000;
        endcase
        return st;
    endfunction

    function automatic level_t mirror_level(level_t lvl);
        return level_t'(TOP_LVL) - lvl;
    endfunction

endpackage

// File: rtl/fcdb_hyst_flag.sv
module fcdb_hyst_flag
    import fcdb_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-1:0] setpoint,
    input  logic [SAMPLE_W-1:0] margin,
    output bal_t                mode_next,
    output bal_t                mode_q
);
    localparam int EXT_W = SAMPLE_W + 1;

    logic [EXT_W-1:0] s_ext, sp_ext, m_ext, upper, s_plus;
    logic             above, below;

    assign s_ext  = {1'b0, sample};
    assign sp_ext = {1'b0, setpoint};
    assign m_ext  = {1'b0, margin};
    assign upper  = sp_ext + m_ext;
    assign s_plus = s_ext + m_ext;
    assign above  = s_ext > upper;
    assign below  = s_plus < sp_ext;

    always_comb begin
        if (above)      mode_next = BAL_DISCHARGE;
        else if (below) mode_next = BAL_CHARGE;
        else            mode_next = mode_q;
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= BAL_CHARGE;
        else     mode_q <= mode_next;
    end

    AST_FLAG_RISE: assert property (@(posedge clk) disable iff (rst)
        above |=> (mode_q == BAL_DISCHARGE)); // R5
    AST_FLAG_FALL: assert property (@(posedge clk) disable iff (rst)
        below |=> (mode_q == BAL_CHARGE)); // R5
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!above && !below) |=> $stable(mode_q)); // R5

endmodule

// File: rtl/fcdb_leg.sv
module fcdb_leg
    import fcdb_pkg::*;
#(
    parameter bit MIRRORED = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   active,
    input  level_t level,
    input  bal_t   mode,
    output gate_t  gates
);
    level_t eff_level;

    generate
        if (MIRRORED) begin : g_mirror
            assign eff_level = mirror_level(level);
        end else begin : g_direct
            assign eff_level = level;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)         gates <= '0;
        else if (active) gates <= pick_state(eff_level, mode);
        else             gates <= '0;
    end

    AST_LEG_IDLE_OFF: assert property (@(posedge clk) disable iff (rst)
        !active |=> (gates == 3'b000)); // R1
    AST_CHARGE_NO_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (active && mode == BAL_CHARGE) |=>
            (gates != 3'b010 && gates != 3'b011 && gates != 3'b110)); // R4
    AST_DRAIN_NO_CHARGE: assert property (@(posedge clk) disable iff (rst)
        (active && mode == BAL_DISCHARGE) |=>
            (gates != 3'b100 && gates != 3'b101)); // R4

endmodule

// File: rtl/fcdb_switch_selector.sv
module fcdb_switch_selector
    import fcdb_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cur_neg,
    input  logic [1:0]          region,
    input  logic                pwm,
    input  logic [SAMPLE_W-1:0] cap1_sample,
    input  logic [SAMPLE_W-1:0] cap2_sample,
    input  logic [SAMPLE_W-1:0] setpoint,
    input  logic [SAMPLE_W-1:0] margin,
    output logic [2:0]          gate_a,
    output logic [2:0]          gate_b
);
    localparam int NUM_LEGS = 2;

    level_t              level;
    logic [SAMPLE_W-1:0] caps   [NUM_LEGS];
    logic                act    [NUM_LEGS];
    gate_t               leg_g  [NUM_LEGS];

    assign level   = level_t'(region) + level_t'(pwm);
    assign caps[0] = cap1_sample;
    assign caps[1] = cap2_sample;
    assign act[0]  = !cur_neg;
    assign act[1]  = cur_neg;

    generate
        for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
            bal_t mode_n, mode_r;

            fcdb_hyst_flag #(.SAMPLE_W(SAMPLE_W)) flag_i (
                .clk      (clk),
                .rst      (rst),
                .sample   (caps[g]),
                .setpoint (setpoint),
                .margin   (margin),
                .mode_next(mode_n),
                .mode_q   (mode_r)
            );

            fcdb_leg #(.MIRRORED(g == 1)) leg_i (
                .clk   (clk),
                .rst   (rst),
                .active(act[g]),
                .level (level),
                .mode  (mode_n),
                .gates (leg_g[g])
            );
        end
    endgenerate

    assign gate_a = leg_g[0];
    assign gate_b = leg_g[1];

    AST_RESET_OFF: assert property (@(posedge clk)
        rst |=> (gate_a == 3'b000 && gate_b == 3'b000)); // R9
    AST_ONE_LEG: assert property (@(posedge clk) disable iff (rst)
        !(gate_a != 3'b000 && gate_b != 3'b000)); // R1

endmodule

// File: tb/fcdb_switch_selector_tb_top.sv
module fcdb_switch_selector_tb_top;

    localparam logic [11:0] LO = 12'd1900;
    localparam logic [11:0] MD = 12'd2048;
    localparam logic [11:0] HI = 12'd2200;
    localparam int NV = 27;

    // {cur_neg, region, pwm, cap1, cap2, expect_a, expect_b}
    localparam logic [33:0] VEC [NV] = '{
        {1'b0, 2'd0, 1'b0, LO, MD, 3'b000, 3'b000},
        {1'b0, 2'd0, 1'b1, LO, MD, 3'b001, 3'b000},
        {1'b0, 2'd1, 1'b1, LO, MD, 3'b100, 3'b000},
        {1'b0, 2'd2, 1'b1, LO, MD, 3'b101, 3'b000},
        {1'b0, 2'd3, 1'b1, LO, MD, 3'b111, 3'b000},
        {1'b0, 2'd3, 1'b0, HI, MD, 3'b110, 3'b000},
        {1'b0, 2'd2, 1'b0, MD, MD, 3'b011, 3'b000},
        {1'b0, 2'd1, 1'b0, MD, MD, 3'b010, 3'b000},
        {1'b0, 2'd0, 1'b0, MD, MD, 3'b000, 3'b000},
        {1'b0, 2'd1, 1'b1, LO, MD, 3'b100, 3'b000},
        {1'b0, 2'd1, 1'b1, 12'd2112, MD, 3'b100, 3'b000},
        {1'b0, 2'd1, 1'b1, 12'd2113, MD, 3'b011, 3'b000},
        {1'b0, 2'd1, 1'b1, 12'd1984, MD, 3'b011, 3'b000},
        {1'b0, 2'd1, 1'b1, 12'd1983, MD, 3'b100, 3'b000},
        {1'b1, 2'd0, 1'b0, MD, MD, 3'b000, 3'b111},
        {1'b1, 2'd0, 1'b1, MD, MD, 3'b000, 3'b101},
        {1'b1, 2'd1, 1'b1, MD, MD, 3'b000, 3'b100},
        {1'b1, 2'd2, 1'b1, MD, MD, 3'b000, 3'b001},
        {1'b1, 2'd3, 1'b1, MD, MD, 3'b000, 3'b000},
        {1'b1, 2'd1, 1'b1, MD, HI, 3'b000, 3'b011},
        {1'b1, 2'd0, 1'b1, MD, MD, 3'b000, 3'b110},
        {1'b1, 2'd2, 1'b1, MD, MD, 3'b000, 3'b010},
        {1'b0, 2'd1, 1'b1, MD, LO, 3'b100, 3'b000},
        {1'b1, 2'd1, 1'b1, MD, MD, 3'b000, 3'b100},
        {1'b0, 2'd2, 1'b0, HI, HI, 3'b011, 3'b000},
        {1'b1, 2'd2, 1'b0, MD, MD, 3'b000, 3'b011},
        {1'b0, 2'd1, 1'b1, MD, MD, 3'b011, 3'b000}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        cur_neg;
    logic [1:0]  region;
    logic        pwm;
    logic [11:0] cap1_sample, cap2_sample, setpoint, margin;
    logic [2:0]  gate_a, gate_b;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    fcdb_switch_selector dut_i (
        .clk(clk), .rst(rst), .cur_neg(cur_neg), .region(region), .pwm(pwm),
        .cap1_sample(cap1_sample), .cap2_sample(cap2_sample),
        .setpoint(setpoint), .margin(margin), .gate_a(gate_a), .gate_b(gate_b)
    );

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cur_neg = 1'b0; region = 2'd3; pwm = 1'b1;
        cap1_sample = MD; cap2_sample = MD; setpoint = MD; margin = 12'd64;
        @(negedge clk);
        step();
        // R9 reset state
        check("R9 reset gate_a", gate_a, 3'b000);
        check("R9 reset gate_b", gate_b, 3'b000);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            string tag;
            {cur_neg, region, pwm, cap1_sample, cap2_sample} = VEC[i][33:6];
            step();
            if (i < 9)       tag = "R2 R3 R4";
            else if (i < 14) tag = "R5";
            else if (i < 22) tag = "R6";
            else             tag = "R10";
            check(tag, VEC[i][33] ? gate_b : gate_a, VEC[i][33] ? VEC[i][2:0] : VEC[i][5:3]);
            check("R1 idle leg", VEC[i][33] ? gate_a : gate_b, 3'b000);
        end

        // R8: inputs change between edges, outputs hold until the edge
        cur_neg = 1'b0; region = 2'd3; pwm = 1'b1;
        step();
        check("R8 settled", gate_a, 3'b111);
        region = 2'd0; pwm = 1'b0;
        #5;
        check("R8 hold between edges", gate_a, 3'b111);
        @(negedge clk);
        check("R8 updated at edge", gate_a, 3'b000);

        // R9 mid-run reset, R7 demand back to charge (leg A demand was discharge)
        region = 2'd3; pwm = 1'b1; cap1_sample = MD; cap2_sample = MD;
        step();
        rst = 1'b1;
        step();
        check("R9 reset mid-run a", gate_a, 3'b000);
        rst = 1'b0; region = 2'd1; pwm = 1'b1;
        step();
        check("R7 leg A charge after reset", gate_a, 3'b100);
        cur_neg = 1'b1;
        step();
        check("R7 leg B charge after reset", gate_b, 3'b100);
        check("R1 leg A idle", gate_a, 3'b000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule